// File: doc/BRIEF.md
# Inter-core data marshal buffer

This unit sits beside one core. It watches that core's commit stream and records the physical cache block address of every store that software has tagged as a generator, meaning the last write to a block that the next program segment will read on another core. Ordinary stores and loads pass by unrecorded, and a block already held for the current segment is not stored twice.

At a segment boundary a marshal command arrives. It is an explicit marshal, a critical-section call or a critical-section return, and it carries a core number. The unit then drains the recorded block addresses oldest first toward an interconnect or cache port as push requests, each tagged with the destination core, using a valid/ready handshake. Recording continues during a drain in a second bank, so the next segment's blocks are kept apart from the set being sent. A full bank drops new addresses and counts the drops. Dropping is safe because a push is only a performance hint.

Top module: `marshal_unit`

## Requirements
- R1: An address is recorded only when `commit_valid_i`, `commit_store_i` and `commit_gen_i` are all 1 in the same cycle. Any other commit leaves `occupancy_o` unchanged.
- R2: A generator store whose block address is already held in the recording bank allocates no second entry and does not count as a drop.
- R3: Each bank holds DEPTH entries (16 by default). A new distinct address that arrives at a full bank is discarded, and `overflow_o` rises by one, saturating at its maximum.
- R4: A marshal command with a non-empty recording bank starts a drain on the next cycle. The drain presents one push request per accepted transfer, in insertion order. While `push_ready_i` is 0, `push_addr_o` and `push_core_o` hold steady.
- R5: The destination core is set by the `marshal_kind_i` code. Code 0 (explicit) and code 2 (critical-section return) send to `marshal_core_i`. Code 1 (critical-section call) sends to core LARGE_CORE (0 by default).
- R6: On the cycle after the last entry is accepted, `push_valid_o` is 0 and the drained set is cleared, so a later marshal pushes none of it again.
- R7: A generator store that commits during a drain goes into the other bank. It is counted in `occupancy_o` and is sent only by the next marshal.
- R8: A marshal command that finds the recording bank empty issues no push request.
- R9: A generator store that commits in the same cycle as a marshal command that starts a drain belongs to the next segment and is not part of that drain.
- R10: After reset, `push_valid_o` is 0, `occupancy_o` is 0 and `overflow_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| commit_valid_i | input | 1 | An instruction commits this cycle |
| commit_store_i | input | 1 | The committing instruction is a store |
| commit_gen_i | input | 1 | The store carries the generator tag |
| commit_addr_i | input | AW | Physical block address of the store |
| marshal_valid_i | input | 1 | Marshal command this cycle |
| marshal_kind_i | input | 2 | 0 explicit, 1 critical-section call, 2 critical-section return |
| marshal_core_i | input | CORE_W | Core number carried by the command |
| push_valid_o | output | 1 | A push request is presented |
| push_ready_i | input | 1 | Downstream accepts the push request |
| push_addr_o | output | AW | Block address to push |
| push_core_o | output | CORE_W | Destination core of the push |
| occupancy_o | output | $clog2(DEPTH+1) | Entries held for the current segment |
| overflow_o | output | OVF_W | Saturating count of dropped addresses |

## Verification
The assertions assume that a marshal command never arrives while a drain is in progress, that is while `push_valid_o` is 1. They also assume that kind code 3 never appears. The bench keeps to this by waiting, after every command, until `push_valid_o` has fallen before it issues the next one, and it only uses codes 0 to 2. Commits, including commits that coincide with a command or a stalled push, may arrive freely, and the bench drives them in exactly those positions.

// File: rtl/marshal_pkg.sv
package marshal_pkg;
  typedef enum logic [1:0] {
    MK_EXPLICIT = 2'd0,
    MK_CS_CALL  = 2'd1,
    MK_CS_RET   = 2'd2
  } mk_kind_e;
endpackage

// File: rtl/mb_bank.sv
module mb_bank #(
  parameter int AW    = 48,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          clr_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic          hit_o,
  output logic          full_o,
  output logic [CW-1:0] count_o,
  output logic [AW-1:0] rd_addr_o
);
  logic [AW-1:0]    mem_q [DEPTH];
  logic [CW-1:0]    count_q;
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = (CW'(g) < count_q) && (mem_q[g] == wr_addr_i);
  end

  assign hit_o     = |match;
  assign full_o    = (count_q == CW'(DEPTH));
  assign count_o   = count_q;
  assign rd_addr_o = mem_q[rd_idx_i];

  wire alloc = wr_i && !hit_o && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_q <= '0;
    else if (clr_i) count_q <= '0;
    else if (alloc) count_q <= count_q + CW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (alloc) mem_q[count_q[IW-1:0]] <= wr_addr_i;
  end

  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  a_r2_no_dup_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_o && !clr_i) |=> $stable(count_q));
  a_r7_no_clr_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && wr_i));
endmodule

// File: rtl/mb_drain.sv
module mb_drain #(
  parameter int IW     = 4,
  parameter int CW     = 5,
  parameter int CORE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [CORE_W-1:0] dest_i,
  input  logic              ready_i,
  output logic              busy_o,
  output logic [IW-1:0]     idx_o,
  output logic [CORE_W-1:0] dest_o,
  output logic              done_o
);
  logic              busy_q;
  logic [IW-1:0]     idx_q, last_q;
  logic [CORE_W-1:0] dest_q;

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign dest_o = dest_q;
  assign done_o = busy_q && ready_i && (idx_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      dest_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      last_q <= IW'(cnt_i - CW'(1));
      dest_q <= dest_i;
    end else if (busy_q && ready_i) begin
      if (idx_q == last_q) busy_q <= 1'b0;
      else                 idx_q  <= idx_q + IW'(1);
    end
  end

  a_r4_step_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ready_i && !done_o) |=> (busy_q && idx_q == $past(idx_q) + IW'(1)));
  a_r4_start_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && idx_q == '0));
endmodule

// File: rtl/marshal_unit.sv
module marshal_unit
  import marshal_pkg::*;
#(
  parameter int AW         = 48,
  parameter int DEPTH      = 16,
  parameter int CORE_W     = 5,
  parameter int LARGE_CORE = 0,
  parameter int OVF_W      = 8,
  localparam int IW        = $clog2(DEPTH),
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_valid_i,
  input  logic              commit_store_i,
  input  logic              commit_gen_i,
  input  logic [AW-1:0]     commit_addr_i,
  input  logic              marshal_valid_i,
  input  logic [1:0]        marshal_kind_i,
  input  logic [CORE_W-1:0] marshal_core_i,
  output logic              push_valid_o,
  input  logic              push_ready_i,
  output logic [AW-1:0]     push_addr_o,
  output logic [CORE_W-1:0] push_core_o,
  output logic [CW-1:0]     occupancy_o,
  output logic [OVF_W-1:0]  overflow_o
);
  logic              rec_q, drn_q;
  logic [OVF_W-1:0]  ovf_q;
  logic [1:0]        hit, full, wr, clr;
  logic [CW-1:0]     cnt     [2];
  logic [AW-1:0]     rd_addr [2];
  logic              busy, done, start, tgt, offer, drop;
  logic [IW-1:0]     idx;
  logic [CORE_W-1:0] dest_sel, dest_q;

  assign offer = commit_valid_i && commit_store_i && commit_gen_i;
  assign start = marshal_valid_i && !busy && (cnt[rec_q] != '0);
  assign tgt   = start ? ~rec_q : rec_q;   // same-cycle store joins next segment
  assign drop  = offer && !hit[tgt] && full[tgt];

  always_comb begin
    case (mk_kind_e'(marshal_kind_i))
      MK_CS_CALL: dest_sel = CORE_W'(LARGE_CORE);
      default:    dest_sel = marshal_core_i;
    endcase
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign wr[b]  = offer && (tgt == 1'(b));
    assign clr[b] = done && (drn_q == 1'(b));
    mb_bank #(.AW(AW), .DEPTH(DEPTH)) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr[b]),
      .wr_addr_i (commit_addr_i),
      .clr_i     (clr[b]),
      .rd_idx_i  (idx),
      .hit_o     (hit[b]),
      .full_o    (full[b]),
      .count_o   (cnt[b]),
      .rd_addr_o (rd_addr[b])
    );
  end

  mb_drain #(.IW(IW), .CW(CW), .CORE_W(CORE_W)) i_drain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .cnt_i   (cnt[rec_q]),
    .dest_i  (dest_sel),
    .ready_i (push_ready_i),
    .busy_o  (busy),
    .idx_o   (idx),
    .dest_o  (dest_q),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= 1'b0;
      drn_q <= 1'b0;
      ovf_q <= '0;
    end else begin
      if (start) begin
        rec_q <= ~rec_q;
        drn_q <= rec_q;
      end
      if (drop && ovf_q != '1) ovf_q <= ovf_q + OVF_W'(1);
    end
  end

  assign push_valid_o = busy;
  assign push_addr_o  = rd_addr[drn_q];
  assign push_core_o  = dest_q;
  assign occupancy_o  = cnt[rec_q];
  assign overflow_o   = ovf_q;

  a_r4_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_o && !push_ready_i) |=>
      (push_valid_o && $stable(push_addr_o) && $stable(push_core_o)));
  a_r4_no_cmd_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(marshal_valid_i && push_valid_o));
  a_r5_kind_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    marshal_valid_i |-> (marshal_kind_i != 2'd3));
  a_r8_empty_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (marshal_valid_i && !push_valid_o && occupancy_o == '0) |=> !push_valid_o);
  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !push_valid_o);
  a_r3_drop_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop && overflow_o != '1) |=> (overflow_o == $past(overflow_o) + OVF_W'(1)));
  a_r1_ignore_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!offer && !marshal_valid_i && !push_valid_o) |=> $stable(occupancy_o));
endmodule

// File: tb/test_marshal_unit.sv
module test_marshal_unit;
  localparam int AW = 48, CORE_W = 5, CW = 5, OVF_W = 8;
  localparam logic [AW-1:0] BASE = 48'h0F00_0000_0000;
  // {exp occupancy[15:11], unused[10], store[9], gen[8], key[7:0]}
  localparam logic [15:0] VEC [8] = '{
    {5'd1, 1'b0, 1'b1, 1'b1, 8'd1},
    {5'd2, 1'b0, 1'b1, 1'b1, 8'd2},
    {5'd2, 1'b0, 1'b1, 1'b0, 8'd3},
    {5'd2, 1'b0, 1'b0, 1'b1, 8'd4},
    {5'd2, 1'b0, 1'b1, 1'b1, 8'd1},
    {5'd3, 1'b0, 1'b1, 1'b1, 8'd5},
    {5'd3, 1'b0, 1'b1, 1'b1, 8'd2},
    {5'd4, 1'b0, 1'b1, 1'b1, 8'd6}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic commit_valid_i = 0, commit_store_i = 0, commit_gen_i = 0;
  logic [AW-1:0] commit_addr_i = '0;
  logic marshal_valid_i = 0;
  logic [1:0] marshal_kind_i = '0;
  logic [CORE_W-1:0] marshal_core_i = '0;
  logic push_valid_o, push_ready_i = 0;
  logic [AW-1:0] push_addr_o;
  logic [CORE_W-1:0] push_core_o;
  logic [CW-1:0] occupancy_o;
  logic [OVF_W-1:0] overflow_o;

  int checks = 0, failures = 0;
  int exp_keys [20];
  int exp_n;

  always #4 clk = ~clk;

  marshal_unit i_marshal_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .commit_valid_i(commit_valid_i), .commit_store_i(commit_store_i),
    .commit_gen_i(commit_gen_i), .commit_addr_i(commit_addr_i),
    .marshal_valid_i(marshal_valid_i), .marshal_kind_i(marshal_kind_i),
    .marshal_core_i(marshal_core_i), .push_valid_o(push_valid_o),
    .push_ready_i(push_ready_i), .push_addr_o(push_addr_o),
    .push_core_o(push_core_o), .occupancy_o(occupancy_o),
    .overflow_o(overflow_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_commit(input int key, input bit gen, input bit st);
    commit_valid_i = 1'b1; commit_gen_i = gen; commit_store_i = st;
    commit_addr_i  = BASE + AW'(key);
  endtask

  task automatic idle_commit();
    commit_valid_i = 1'b0; commit_gen_i = 1'b0; commit_store_i = 1'b0;
  endtask

  task automatic commit_one(input int key, input bit gen, input bit st);
    drive_commit(key, gen, st);
    @(negedge clk);
    idle_commit();
  endtask

  task automatic marshal(input logic [1:0] kind, input int core);
    marshal_valid_i = 1'b1; marshal_kind_i = kind;
    marshal_core_i = CORE_W'(core);
    @(negedge clk);
    marshal_valid_i = 1'b0;
  endtask

  task automatic drain_check(input int dest, input string req);
    push_ready_i = 1'b1;
    for (int i = 0; i < exp_n; i++) begin
      chk(push_valid_o == 1'b1, req, 64'(push_valid_o), 64'd1);
      chk(push_addr_o == BASE + AW'(exp_keys[i]), req, 64'(push_addr_o),
          64'(BASE + AW'(exp_keys[i])));
      chk(push_core_o == CORE_W'(dest), req, 64'(push_core_o), 64'(dest));
      @(negedge clk);
    end
    chk(push_valid_o == 1'b0, "R6 drain ends", 64'(push_valid_o), 64'd0);
    push_ready_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(push_valid_o == 1'b0, "R10 valid", 64'(push_valid_o), 64'd0);
    chk(occupancy_o == '0, "R10 occupancy", 64'(occupancy_o), 64'd0);
    chk(overflow_o == '0, "R10 overflow", 64'(overflow_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // vector walk: R1 filtering and R2 dedup
    for (int i = 0; i < 8; i++) begin
      commit_one(int'(VEC[i][7:0]), VEC[i][8], VEC[i][9]);
      chk(occupancy_o == VEC[i][15:11], "R1/R2 occupancy", 64'(occupancy_o),
          64'(VEC[i][15:11]));
      chk(push_valid_o == 1'b0, "R1 no push", 64'(push_valid_o), 64'd0);
    end

    // explicit marshal with stalled ready and a store during the drain
    marshal(2'd0, 7);
    chk(occupancy_o == '0, "R7 swap", 64'(occupancy_o), 64'd0);
    chk(push_addr_o == BASE + AW'(1), "R4 oldest first", 64'(push_addr_o),
        64'(BASE + AW'(1)));
    commit_one(7, 1'b1, 1'b1);
    chk(occupancy_o == CW'(1), "R7 second bank", 64'(occupancy_o), 64'd1);
    chk(push_valid_o && push_addr_o == BASE + AW'(1), "R4 hold",
        64'(push_addr_o), 64'(BASE + AW'(1)));
    exp_n = 4; exp_keys[0] = 1; exp_keys[1] = 2; exp_keys[2] = 5; exp_keys[3] = 6;
    drain_check(7, "R4 R5 explicit drain");
    chk(occupancy_o == CW'(1), "R7 kept", 64'(occupancy_o), 64'd1);

    // call goes to the large core; only the new entry is pushed (R6)
    marshal(2'd1, 3);
    exp_n = 1; exp_keys[0] = 7;
    drain_check(0, "R5 R6 call drain");
    chk(occupancy_o == '0, "R6 cleared", 64'(occupancy_o), 64'd0);

    // empty marshal
    marshal(2'd0, 4);
    chk(push_valid_o == 1'b0, "R8 empty", 64'(push_valid_o), 64'd0);
    @(negedge clk);
    chk(push_valid_o == 1'b0, "R8 still idle", 64'(push_valid_o), 64'd0);

    // fill and overflow
    for (int k = 16; k < 34; k++) commit_one(k, 1'b1, 1'b1);
    chk(occupancy_o == CW'(16), "R3 full", 64'(occupancy_o), 64'd16);
    chk(overflow_o == OVF_W'(2), "R3 drops", 64'(overflow_o), 64'd2);
    commit_one(16, 1'b1, 1'b1);
    chk(overflow_o == OVF_W'(2), "R2 dup not dropped", 64'(overflow_o), 64'd2);

    marshal(2'd2, 9);
    exp_n = 16;
    for (int i = 0; i < 16; i++) exp_keys[i] = 16 + i;
    drain_check(9, "R4 R5 return drain");

    // store in the same cycle as a command
    commit_one(40, 1'b1, 1'b1);
    drive_commit(41, 1'b1, 1'b1);
    marshal(2'd0, 2);
    idle_commit();
    chk(occupancy_o == CW'(1), "R9 next segment", 64'(occupancy_o), 64'd1);
    exp_n = 1; exp_keys[0] = 40;
    drain_check(2, "R9 drain");
    marshal(2'd0, 5);
    exp_n = 1; exp_keys[0] = 41;
    drain_check(5, "R9 later drain");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule